// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

The block holds a set of data watchpoints and checks every memory access against all of them in the same cycle. Each watchpoint has an address register and a control register. The control register turns on matching for reads, for writes or for both, and carries a mask field that sets the size of the watched region. An access that falls inside an armed region, in a direction that watchpoint is enabled for, raises that watchpoint's hit bit and a combined hit flag. Both are combinational from the access request, so the pipeline can act on them before the access commits.

Software programs the watchpoints through a single-cycle write port. Each write selects a watchpoint and either its address or its control register. A mask field that is not a single run of ones from its top bit is repaired while it is written: the run of ones below the highest zero is dropped. Every watched region is therefore an aligned power-of-two block of bytes. Its size is the inverted full mask plus one.

Top module: `dbrk_match`

## Requirements
- R1: After reset, every control register is zero, so no watchpoint reports a hit for any access.
- R2: Control bit 1 (store enable) makes a watchpoint match write accesses (`acc_write`=1). With only this bit set, reads never match.
- R3: Control bit 0 (load enable) makes a watchpoint match read accesses (`acc_write`=0). With only this bit set, writes never match. With both bits set, both directions match.
- R4: The full mask is the control mask field (control bits [MW+1:2], which map onto address bits [MW-1:0]) with every address bit above MW-1 forced to one. An access matches when (addr & mask) equals (watch address & mask).
- R5: When a mask field is written, only the leading run of ones counted from its top bit is kept. The highest zero bit and every bit below it read as zero, so the region is always aligned and ~mask+1 bytes long. For example, field 110101 watches 16 bytes and field 011111 watches 64 bytes.
- R6: Hit outputs are combinational from `acc_valid`, `acc_write` and `acc_addr` in the same cycle. When `acc_valid` is 0, no hit bit is set.
- R7: `any_hit` is set exactly when at least one bit of `wp_hit` is set. Several watchpoints can hit on the same access.
- R8: A write with `reg_we`=1 updates the register selected by `reg_idx`: the control register when `reg_ctrl`=1, otherwise the address register. The new value governs matching from the next cycle. Control bits above MW+1 are ignored.
- R9: A watchpoint with both enable bits clear never hits, even when its address and mask cover the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ctrl | input | 1 | 1 selects the control register, 0 selects the address register |
| reg_idx | input | IW | Watchpoint index for the write |
| reg_wdata | input | AW | Write data |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | AW | Access byte address |
| wp_hit | output | NUM_WP | Hit bit for each watchpoint |
| any_hit | output | 1 | OR of all hit bits |

## Verification
The assertions assume that `acc_write` is meaningful only while `acc_valid` is high. They also assume that the only path into the stored masks is the write port, so a stored mask field must always be contiguous from its top bit. The stimulus respects both assumptions: register writes go only through `reg_we` at the falling edge. The random mask values are deliberately full of holes, which makes the repair path carry most of the load. Accesses are drawn from a narrow address window around the watched addresses, so hits, near misses and multiple hits all occur often.

// File: rtl/dbrk_match.sv
module dbrk_match #(
  parameter int NUM_WP = 4,
  parameter int AW = 32,
  parameter int MW = 6,
  localparam int IW = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_ctrl,
  input  logic [IW-1:0]     reg_idx,
  input  logic [AW-1:0]     reg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  output logic [NUM_WP-1:0] wp_hit,
  output logic              any_hit
);

  logic [NUM_WP-1:0]         ld_q, st_q;
  logic [NUM_WP-1:0][AW-1:0] addr_q;
  logic [NUM_WP-1:0][MW-1:0] mask_q;
  logic [MW-1:0]             mask_fix;

  always_comb begin
    logic run;
    run = 1'b1;
    for (int b = MW - 1; b >= 0; b--) begin
      run = run & reg_wdata[b+2];
      mask_fix[b] = run;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WP; i++) begin
      if (!rst_n) begin
        ld_q[i]   <= 1'b0;
        st_q[i]   <= 1'b0;
        mask_q[i] <= '0;
        addr_q[i] <= '0;
      end else if (reg_we && reg_idx == IW'(i)) begin
        if (reg_ctrl) begin
          ld_q[i]   <= reg_wdata[0];
          st_q[i]   <= reg_wdata[1];
          mask_q[i] <= mask_fix;
        end else begin
          addr_q[i] <= reg_wdata;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic [AW-1:0] full_mask;
    logic          dir_ok;
    assign full_mask = {{(AW-MW){1'b1}}, mask_q[g]};
    assign dir_ok    = acc_write ? st_q[g] : ld_q[g];
    assign wp_hit[g] = acc_valid & dir_ok & (((acc_addr ^ addr_q[g]) & full_mask) == '0);
  end

  assign any_hit = |wp_hit;

endmodule

// File: rtl/dbrk_match_chk.sv
module dbrk_match_chk #(
  parameter int NUM_WP = 4,
  parameter int MW = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_valid,
  input logic                      acc_write,
  input logic [NUM_WP-1:0]         wp_hit,
  input logic                      any_hit,
  input logic [NUM_WP-1:0]         ld_q,
  input logic [NUM_WP-1:0]         st_q,
  input logic [NUM_WP-1:0][MW-1:0] mask_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> wp_hit == '0); // R1
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |-> wp_hit == '0); // R6
  AST_ANY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) any_hit |-> acc_valid); // R7

  for (genvar g = 0; g < NUM_WP; g++) begin : g_chk
    AST_STORE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (wp_hit[g] && acc_write) |-> st_q[g]); // R2
    AST_LOAD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (wp_hit[g] && !acc_write) |-> ld_q[g]); // R3
    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) ((MW'(~mask_q[g] + 1'b1)) & ~mask_q[g]) == '0); // R5
    AST_IDLE_WP: assert property (@(posedge clk) disable iff (!rst_n) !(ld_q[g] || st_q[g]) |-> !wp_hit[g]); // R9
  end

endmodule

bind dbrk_match dbrk_match_chk #(.NUM_WP(NUM_WP), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .wp_hit(wp_hit), .any_hit(any_hit), .ld_q(ld_q), .st_q(st_q), .mask_q(mask_q)
);

// File: tb/sim_dbrk_match.sv
module sim_dbrk_match;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int MW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_ctrl = 1'b0;
  logic [IW-1:0] reg_idx = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [N-1:0] wp_hit;
  logic any_hit;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_addr [N];
  logic          m_ld [N];
  logic          m_st [N];
  logic [MW-1:0] m_mf [N];

  always #5 clk = ~clk;

  dbrk_match #(.NUM_WP(N), .AW(AW), .MW(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ctrl(reg_ctrl), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .wp_hit(wp_hit), .any_hit(any_hit)
  );

  function automatic logic [MW-1:0] fix_mask(logic [MW-1:0] f);
    int c = 0;
    while (c < MW && f[MW-1-c]) c++;
    return ~MW'((1 << (MW - c)) - 1);
  endfunction

  function automatic logic [N-1:0] predict(logic v, logic w, logic [AW-1:0] a);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      logic [AW-1:0] em = {{(AW-MW){1'b1}}, m_mf[i]};
      logic en = w ? m_st[i] : m_ld[i];
      r[i] = v && en && ((a & em) == (m_addr[i] & em));
    end
    return r;
  endfunction

  task automatic wr(input int idx, input logic c, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ctrl = c; reg_idx = IW'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (c) begin
      m_ld[idx] = d[0]; m_st[idx] = d[1]; m_mf[idx] = fix_mask(d[MW+1:2]);
    end else m_addr[idx] = d;
  endtask

  task automatic ctl(input int idx, input logic ld, input logic st, input logic [MW-1:0] mf);
    wr(idx, 1'b1, {{(AW-MW-2){1'b0}}, mf, st, ld});
  endtask

  task automatic acc(input string req, input logic v, input logic w, input logic [AW-1:0] a);
    logic [N-1:0] e;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a;
    #1;
    e = predict(v, w, a);
    checks++;
    if (wp_hit !== e || any_hit !== (|e)) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0b v=%0b hit=%b any=%b expected hit=%b any=%b",
               req, a, w, v, wp_hit, any_hit, e, |e);
    end
  endtask

  task automatic acc_exp(input string req, input logic v, input logic w, input logic [AW-1:0] a,
                         input logic [N-1:0] e);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a;
    #1;
    checks++;
    if (wp_hit !== e || any_hit !== (|e)) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0b hit=%b any=%b expected hit=%b any=%b",
               req, a, w, wp_hit, any_hit, e, |e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      m_addr[i] = '0; m_ld[i] = 1'b0; m_st[i] = 1'b0; m_mf[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    acc_exp("R1", 1'b1, 1'b0, 32'h0, 4'b0000);
    acc_exp("R1", 1'b1, 1'b1, 32'h0, 4'b0000);

    wr(0, 1'b0, 32'h1000);
    ctl(0, 1'b0, 1'b1, 6'b111100);
    acc_exp("R2", 1'b1, 1'b1, 32'h1002, 4'b0001);
    acc_exp("R2", 1'b1, 1'b0, 32'h1002, 4'b0000);

    ctl(0, 1'b1, 1'b0, 6'b111100);
    acc_exp("R3", 1'b1, 1'b0, 32'h1003, 4'b0001);
    acc_exp("R3", 1'b1, 1'b1, 32'h1003, 4'b0000);
    ctl(0, 1'b1, 1'b1, 6'b111100);
    acc_exp("R3", 1'b1, 1'b1, 32'h1000, 4'b0001);

    acc_exp("R4", 1'b1, 1'b0, 32'h1004, 4'b0000);
    acc_exp("R4", 1'b1, 1'b0, 32'h0001_1000, 4'b0000);
    acc_exp("R4", 1'b1, 1'b0, 32'h0FFF, 4'b0000);

    ctl(0, 1'b1, 1'b1, 6'b110101);
    acc_exp("R5", 1'b1, 1'b0, 32'h100F, 4'b0001);
    acc_exp("R5", 1'b1, 1'b0, 32'h1010, 4'b0000);
    ctl(0, 1'b1, 1'b1, 6'b011111);
    acc_exp("R5", 1'b1, 1'b1, 32'h103F, 4'b0001);
    acc_exp("R5", 1'b1, 1'b1, 32'h1040, 4'b0000);

    acc_exp("R6", 1'b0, 1'b1, 32'h1000, 4'b0000);

    wr(1, 1'b0, 32'h1020);
    ctl(1, 1'b1, 1'b0, 6'b111000);
    acc_exp("R7", 1'b1, 1'b0, 32'h1024, 4'b0011);
    acc_exp("R7", 1'b1, 1'b1, 32'h1024, 4'b0001);

    wr(1, 1'b0, 32'h2000);
    acc_exp("R8", 1'b1, 1'b0, 32'h1024, 4'b0001);
    acc_exp("R8", 1'b1, 1'b0, 32'h2004, 4'b0010);
    wr(1, 1'b1, 32'hFFFF_FF00 | {24'h0, 6'b111000, 1'b0, 1'b1});
    acc_exp("R8", 1'b1, 1'b0, 32'h2007, 4'b0010);
    acc_exp("R8", 1'b1, 1'b0, 32'h2008, 4'b0000);

    ctl(0, 1'b0, 1'b0, 6'b011111);
    acc_exp("R9", 1'b1, 1'b0, 32'h1000, 4'b0000);
    acc_exp("R9", 1'b1, 1'b1, 32'h1000, 4'b0000);

    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(7) == 0) begin
        int idx = $urandom_range(N - 1);
        if ($urandom_range(1) == 0)
          wr(idx, 1'b0, 32'h1000 | ($urandom & 32'hFF));
        else
          wr(idx, 1'b1, $urandom);
      end
      acc("R4 random", $urandom_range(9) != 0, $urandom_range(1) == 1,
          32'h1000 | ($urandom & 32'hFF));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule